// File: doc/BRIEF.md
# Per-Channel Link Alarm and Error Counter Bank

This block is the host-visible status bank of a four-channel framed serial link receiver. For every channel it counts three kinds of receive event: byte-parity errors, loss-of-frame events and framing-pattern errors. Each count is a 7-bit value with a sticky overflow bit. The count stops at its ceiling and does not wrap, and reading a counter clears it. Each channel also collects twelve sticky elastic-store overflow flags, each with an enable bit. The enabled flags of all channels are ORed into a single alarm output.

The host reaches the bank through a plain address / read-enable / write-enable port. Read data appears one cycle after the request and holds until the next read. Each channel also has two injection controls, one for framing corruption and one for parity corruption. Each control is a small state machine with the states IDLE, FIRE and HELD, driven by writes to the channel's control register:

- Writing 1 in IDLE moves it to FIRE.
- FIRE always lasts one cycle. It moves to HELD, or back to IDLE if a 0 is written during that cycle.
- HELD stays put while 1 is written again.
- Writing 0 returns it to IDLE.

The injection output of a control is high only in FIRE. So a corruption needs a 0-to-1 change of the control bit, and the control must be rearmed with a 0 before it can fire again.

Top module: `cbank_status_regs`

## Requirements
- R1: Channel c (0..3) occupies addresses 0x20+0x10*c to 0x27+0x10*c. The register offsets are: 0 control (bit0 framing inject, bit1 parity inject), 1 overflow flags 11..8 in bits 3:0, 2 overflow flags 7..0, 3 enables for flags 11..8 in bits 3:0, 4 enables for flags 7..0, 5 parity counter, 6 loss-of-frame counter, 7 framing counter.
- R2: After reset every mapped register reads 0x00, and all injection outputs and the alarm output are low.
- R3: Each event strobe that is high at a clock edge adds one to its channel's counter. A counter reads as bit7 = overflow and bits6:0 = count. When rd_en is high at an edge, rd_data shows the addressed value from the next cycle and holds it until the next read.
- R4: Reading a counter clears both its count and its overflow bit.
- R5: An event that arrives with the count at 127 leaves the count at 127 and sets the overflow bit. The overflow bit stays set until the counter is read, so a read then returns 0xFF.
- R6: If an event arrives in the same cycle as a read of its counter, the read returns the old value and the counter is 1 afterwards.
- R7: A high bit j of a channel's es_ovf slice (es_ovf[12*c+j]) sets flag j, and the flag stays set until its flag register is read. A flag event that coincides with that read leaves the flag set.
- R8: The enable registers are writable and read back their written bits. alarm_any is high in the cycle after any flag whose enable bit is 1 is set, and stays high until all such flags are cleared.
- R9: Writing a control bit as 1 when it is 0 gives exactly one single-cycle pulse on that channel's frm_inj or par_inj, in the cycle after the write. Writing 1 again gives no pulse. Writing 0 rearms the control. The control register reads back the two bits.
- R10: Reads of unmapped addresses (below 0x20, 0x60 and above, and offsets 8..15) return 0x00. Writes to counter and flag registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read request; clears read-to-clear registers |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| par_evt | input | 4 | Per-channel parity error strobe |
| lof_evt | input | 4 | Per-channel loss-of-frame strobe |
| frm_evt | input | 4 | Per-channel framing-pattern error strobe |
| es_ovf | input | 48 | Elastic-store overflow strobes, 12 per channel |
| frm_inj | output | 4 | Per-channel framing corruption pulse |
| par_inj | output | 4 | Per-channel parity corruption pulse |
| alarm_any | output | 1 | OR of all enabled overflow flags |

## Verification
The hardest situations to reach from the ports are the saturated counter and the coincidence of an event with a read of that same counter. Random traffic reads counters too often for a count to climb to 127. A directed sequence therefore first clears one counter and then drives 130 consecutive strobes into it before reading it twice. A second directed sequence asserts a loss-of-frame strobe in the read cycle itself. The injection controls are stepped through every state change, including a repeated 1 while HELD. A random phase with a fixed seed then mixes reads, writes and sparse events across mapped and unmapped addresses. A bench model predicts every read, pulse and alarm level in that phase.

// File: rtl/cbank_pkg.sv
package cbank_pkg;

    typedef enum logic [1:0] {
        INJ_IDLE = 2'd0,
        INJ_FIRE = 2'd1,
        INJ_HELD = 2'd2
    } inj_state_t;

    typedef enum logic [2:0] {
        OFF_CTRL    = 3'd0,
        OFF_FLAG_HI = 3'd1,
        OFF_FLAG_LO = 3'd2,
        OFF_MASK_HI = 3'd3,
        OFF_MASK_LO = 3'd4,
        OFF_CNT_PAR = 3'd5,
        OFF_CNT_LOF = 3'd6,
        OFF_CNT_FRM = 3'd7
    } reg_off_t;

    localparam int NUM_CNT     = 3;
    localparam int REG_PER_CH  = 8;
    localparam int NUM_INJ     = 2;

endpackage

// File: rtl/cbank_sat_counter.sv
module cbank_sat_counter #(
    parameter int CNT_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt,
    input  logic           clr,
    output logic [CNT_W:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            // a read restarts the count; a coincident event is kept
            cnt_q <= evt ? CNT_W'(1) : '0;
            ovf_q <= 1'b0;
        end else if (evt) begin
            if (cnt_q == CNT_MAX) begin
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign value = {ovf_q, cnt_q};

endmodule

// File: rtl/cbank_inject_fsm.sv
module cbank_inject_fsm
    import cbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic pulse,
    output logic armed
);
    inj_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INJ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INJ_IDLE: if (wr_hit && wr_bit) state_d = INJ_FIRE;
            INJ_FIRE: state_d = (wr_hit && !wr_bit) ? INJ_IDLE : INJ_HELD;
            INJ_HELD: if (wr_hit && !wr_bit) state_d = INJ_IDLE;
            default:  state_d = INJ_IDLE;
        endcase
    end

    always_comb begin
        pulse = 1'b0;
        armed = 1'b0;
        unique case (state_q)
            INJ_IDLE: begin pulse = 1'b0; armed = 1'b0; end
            INJ_FIRE: begin pulse = 1'b1; armed = 1'b1; end
            INJ_HELD: begin pulse = 1'b0; armed = 1'b1; end
            default:  begin pulse = 1'b0; armed = 1'b0; end
        endcase
    end

endmodule

// File: rtl/cbank_channel.sv
module cbank_channel
    import cbank_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int FLAG_N = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [2:0]        off,
    input  logic [CNT_W:0]    wdata,
    input  logic              par_evt,
    input  logic              lof_evt,
    input  logic              frm_evt,
    input  logic [FLAG_N-1:0] es_ovf,
    output logic [CNT_W:0]    rd_val,
    output logic              frm_inj,
    output logic              par_inj,
    output logic              alarm
);
    localparam int DATA_W = CNT_W + 1;
    localparam int LO_W   = DATA_W;
    localparam int HI_W   = FLAG_N - LO_W;

    reg_off_t roff;
    assign roff = reg_off_t'(off);

    // event counters: index 0 parity, 1 loss-of-frame, 2 framing
    logic [NUM_CNT-1:0] cnt_evt;
    logic [DATA_W-1:0]  cnt_val [NUM_CNT];
    assign cnt_evt = {frm_evt, lof_evt, par_evt};

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        logic clr_k;
        assign clr_k = rd_hit && (off == 3'(int'(OFF_CNT_PAR) + k));
        cbank_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (cnt_evt[k]),
            .clr   (clr_k),
            .value (cnt_val[k])
        );
    end

    // sticky overflow flags and their enables
    logic [FLAG_N-1:0] flags_q, mask_q, flag_clr;
    assign flag_clr = {{HI_W{rd_hit && roff == OFF_FLAG_HI}},
                       {LO_W{rd_hit && roff == OFF_FLAG_LO}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | es_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_hit && roff == OFF_MASK_HI) begin
            mask_q[FLAG_N-1:LO_W] <= wdata[HI_W-1:0];
        end else if (wr_hit && roff == OFF_MASK_LO) begin
            mask_q[LO_W-1:0] <= wdata;
        end
    end

    assign alarm = |(flags_q & mask_q);

    // injection controls: bit 0 framing, bit 1 parity
    logic [NUM_INJ-1:0] inj_pulse, inj_armed;
    for (genvar b = 0; b < NUM_INJ; b++) begin : g_inj
        cbank_inject_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit && roff == OFF_CTRL),
            .wr_bit (wdata[b]),
            .pulse  (inj_pulse[b]),
            .armed  (inj_armed[b])
        );
    end
    assign frm_inj = inj_pulse[0];
    assign par_inj = inj_pulse[1];

    always_comb begin
        rd_val = '0;
        unique case (roff)
            OFF_CTRL:    rd_val = {{(DATA_W-NUM_INJ){1'b0}}, inj_armed};
            OFF_FLAG_HI: rd_val = {{(DATA_W-HI_W){1'b0}}, flags_q[FLAG_N-1:LO_W]};
            OFF_FLAG_LO: rd_val = flags_q[LO_W-1:0];
            OFF_MASK_HI: rd_val = {{(DATA_W-HI_W){1'b0}}, mask_q[FLAG_N-1:LO_W]};
            OFF_MASK_LO: rd_val = mask_q[LO_W-1:0];
            OFF_CNT_PAR: rd_val = cnt_val[0];
            OFF_CNT_LOF: rd_val = cnt_val[1];
            OFF_CNT_FRM: rd_val = cnt_val[2];
            default:     rd_val = '0;
        endcase
    end

endmodule

// File: rtl/cbank_status_regs.sv
module cbank_status_regs
    import cbank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CNT_W     = 7,
    parameter int FLAG_N    = 12,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 32,
    parameter int CH_STRIDE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [CNT_W:0]           wr_data,
    output logic [CNT_W:0]           rd_data,
    input  logic [NUM_CH-1:0]        par_evt,
    input  logic [NUM_CH-1:0]        lof_evt,
    input  logic [NUM_CH-1:0]        frm_evt,
    input  logic [NUM_CH*FLAG_N-1:0] es_ovf,
    output logic [NUM_CH-1:0]        frm_inj,
    output logic [NUM_CH-1:0]        par_inj,
    output logic                     alarm_any
);
    localparam int DATA_W = CNT_W + 1;
    localparam int OFF_W  = $clog2(CH_STRIDE);
    localparam int SEL_W  = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W:0]   END_X  = (ADDR_W+1)'(CH_BASE + NUM_CH*CH_STRIDE);

    logic [ADDR_W-1:0] rel;
    logic              in_win, off_ok;
    logic [NUM_CH-1:0] sel;
    logic [DATA_W-1:0] ch_val [NUM_CH];
    logic [NUM_CH-1:0] ch_alarm;
    logic [DATA_W-1:0] mux_val;

    assign rel    = addr - BASE_A;
    assign in_win = ({1'b0, addr} >= {1'b0, BASE_A}) && ({1'b0, addr} < END_X);
    assign off_ok = rel[OFF_W-1:0] < OFF_W'(REG_PER_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign sel[c] = in_win && off_ok && (rel[ADDR_W-1:OFF_W] == SEL_W'(c));

        cbank_channel #(.CNT_W(CNT_W), .FLAG_N(FLAG_N)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_en && sel[c]),
            .rd_hit  (rd_en && sel[c]),
            .off     (rel[2:0]),
            .wdata   (wr_data),
            .par_evt (par_evt[c]),
            .lof_evt (lof_evt[c]),
            .frm_evt (frm_evt[c]),
            .es_ovf  (es_ovf[c*FLAG_N +: FLAG_N]),
            .rd_val  (ch_val[c]),
            .frm_inj (frm_inj[c]),
            .par_inj (par_inj[c]),
            .alarm   (ch_alarm[c])
        );
    end

    always_comb begin
        mux_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) mux_val = mux_val | ch_val[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mux_val;
        end
    end

    assign alarm_any = |ch_alarm;

endmodule

// File: rtl/cbank_status_regs_chk.sv
module cbank_status_regs_chk #(
    parameter int NUM_CH    = 4,
    parameter int CNT_W     = 7,
    parameter int FLAG_N    = 12,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 32,
    parameter int CH_STRIDE = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        addr,
    input logic                     rd_en,
    input logic                     wr_en,
    input logic [CNT_W:0]           wr_data,
    input logic [CNT_W:0]           rd_data,
    input logic [NUM_CH*FLAG_N-1:0] es_ovf,
    input logic [NUM_CH-1:0]        frm_inj,
    input logic [NUM_CH-1:0]        par_inj,
    input logic                     alarm_any
);
    logic mapped;
    always_comb begin
        int a;
        a = int'(addr);
        mapped = (a >= CH_BASE) && (a < CH_BASE + NUM_CH*CH_STRIDE)
                 && (((a - CH_BASE) % CH_STRIDE) < 8);
    end

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rd_data == '0));

    // R9
    frm_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((frm_inj & $past(frm_inj)) == '0));

    // R9
    par_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((par_inj & $past(par_inj)) == '0));

    // R9
    inj_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{frm_inj, par_inj}) |-> ($past(wr_en) && $past(|wr_data[1:0])));

    // R8
    alarm_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_any) |-> ($past(|es_ovf) || $past(wr_en)));

endmodule

bind cbank_status_regs cbank_status_regs_chk #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .FLAG_N(FLAG_N),
    .ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
) u_chk (.*);

// File: tb/cbank_status_regs_test.sv
module cbank_status_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  par_evt = '0, lof_evt = '0, frm_evt = '0;
    logic [47:0] es_ovf = '0;
    logic [3:0]  frm_inj, par_inj;
    logic        alarm_any;

    cbank_status_regs uut (.*);

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    logic [7:0]  mcnt [4][3];
    logic [11:0] mflg [4];
    logic [11:0] mmsk [4];
    int          mst  [4][2];
    logic [3:0]  x_frm, x_par;
    logic        x_alarm;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int dec_ch(input logic [7:0] a);
        int v = int'(a);
        if (v < 32 || v >= 96 || ((v - 32) % 16) >= 8) return -1;
        return (v - 32) / 16;
    endfunction

    function automatic int dec_off(input logic [7:0] a);
        return (int'(a) - 32) % 16;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        int c = dec_ch(a);
        int o;
        if (c < 0) return 8'h00;
        o = dec_off(a);
        case (o)
            0: return {6'b0, mst[c][1] != 0, mst[c][0] != 0};
            1: return {4'b0, mflg[c][11:8]};
            2: return mflg[c][7:0];
            3: return {4'b0, mmsk[c][11:8]};
            4: return mmsk[c][7:0];
            default: return mcnt[c][o-5];
        endcase
    endfunction

    task automatic model_edge(input logic [7:0] a, input logic rd, input logic wr,
                              input logic [7:0] wd, input logic [3:0] pe, input logic [3:0] le,
                              input logic [3:0] fe, input logic [47:0] es);
        int ca = dec_ch(a);
        int co = (ca >= 0) ? dec_off(a) : -1;
        x_alarm = 1'b0;
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic ev = (k == 0) ? pe[c] : (k == 1) ? le[c] : fe[c];
                logic cl = rd && ca == c && co == 5 + k;
                if (cl) mcnt[c][k] = ev ? 8'h01 : 8'h00;
                else if (ev) begin
                    if (mcnt[c][k][6:0] == 7'h7F) mcnt[c][k][7] = 1'b1;
                    else mcnt[c][k] = mcnt[c][k] + 8'h01;
                end
            end
            if (rd && ca == c && co == 1) mflg[c][11:8] = 4'h0;
            if (rd && ca == c && co == 2) mflg[c][7:0] = 8'h00;
            mflg[c] = mflg[c] | es[c*12 +: 12];
            if (wr && ca == c && co == 3) mmsk[c][11:8] = wd[3:0];
            if (wr && ca == c && co == 4) mmsk[c][7:0] = wd;
            for (int b = 0; b < 2; b++) begin
                if (wr && ca == c && co == 0) begin
                    if (wd[b]) mst[c][b] = (mst[c][b] == 0) ? 1 : 2;
                    else       mst[c][b] = 0;
                end else if (mst[c][b] == 1) mst[c][b] = 2;
            end
            x_frm[c] = (mst[c][0] == 1);
            x_par[c] = (mst[c][1] == 1);
            if ((mflg[c] & mmsk[c]) != 0) x_alarm = 1'b1;
        end
    endtask

    task automatic step(input logic [7:0] a, input logic rd, input logic wr, input logic [7:0] wd,
                        input logic [3:0] pe, input logic [3:0] le, input logic [3:0] fe,
                        input logic [47:0] es, input string tag);
        logic [7:0] exp_rd;
        addr = a; rd_en = rd; wr_en = wr; wr_data = wd;
        par_evt = pe; lof_evt = le; frm_evt = fe; es_ovf = es;
        @(posedge clk);
        exp_rd = model_read(a);
        model_edge(a, rd, wr, wd, pe, le, fe, es);
        @(negedge clk);
        if (rd) check(32'(rd_data), 32'(exp_rd), tag);
        check(32'(frm_inj), 32'(x_frm), "R9 frm_inj");
        check(32'(par_inj), 32'(x_par), "R9 par_inj");
        check(32'(alarm_any), 32'(x_alarm), "R8 alarm_any");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(a, 1'b1, 1'b0, 8'h00, '0, '0, '0, '0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(a, 1'b0, 1'b1, d, '0, '0, '0, '0, tag);
    endtask

    task automatic ev(input logic [3:0] pe, input logic [3:0] le, input logic [3:0] fe,
                      input logic [47:0] es, input string tag);
        step(8'h00, 1'b0, 1'b0, 8'h00, pe, le, fe, es, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            mflg[c] = '0; mmsk[c] = '0;
            for (int k = 0; k < 3; k++) mcnt[c][k] = '0;
            for (int b = 0; b < 2; b++) mst[c][b] = 0;
        end
        x_frm = '0; x_par = '0; x_alarm = 1'b0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check(32'(rd_data), 32'h0, "R2 rd_data in reset");
        check(32'({frm_inj, par_inj, alarm_any}), 32'h0, "R2 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R1: every mapped register is zero after reset
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 8; o++)
                rd(8'(32 + 16*c + o), "R2 reset value");

        // R3: counting and read format
        repeat (3) ev(4'b0001, '0, '0, '0, "R3");
        repeat (5) ev('0, 4'b1000, '0, '0, "R3");
        repeat (2) ev('0, '0, 4'b0100, '0, "R3");
        rd(8'h25, "R3 ch0 parity count");
        rd(8'h56, "R3 ch3 lof count");
        rd(8'h47, "R3 ch2 framing count");
        // R4: cleared by the read
        rd(8'h25, "R4 ch0 parity after read");
        rd(8'h56, "R4 ch3 lof after read");

        // R5: saturation with sticky overflow
        rd(8'h45, "R4 ch2 parity pre-clear");
        repeat (130) ev(4'b0100, '0, '0, '0, "R5");
        rd(8'h45, "R5 saturated counter");
        rd(8'h45, "R4 after saturated read");

        // R6: event coincident with read
        repeat (3) ev('0, 4'b0010, '0, '0, "R6");
        step(8'h36, 1'b1, 1'b0, 8'h00, '0, 4'b0010, '0, '0, "R6 read with event");
        rd(8'h36, "R6 restart at one");

        // R7: sticky flags, clear on read, coincident set
        ev('0, '0, '0, 48'(1) << 22, "R7");
        ev('0, '0, '0, 48'(1) << 15, "R7");
        rd(8'h31, "R7 ch1 flags hi");
        rd(8'h31, "R7 ch1 flags hi cleared");
        step(8'h32, 1'b1, 1'b0, 8'h00, '0, '0, '0, 48'(1) << 15, "R7 flags lo with event");
        rd(8'h32, "R7 flag kept by coincident event");
        rd(8'h32, "R7 flag cleared");

        // R8: enables and alarm summary
        wr(8'h54, 8'h01, "R8");
        rd(8'h54, "R8 mask lo readback");
        wr(8'h53, 8'hFF, "R8");
        rd(8'h53, "R8 mask hi readback");
        ev('0, '0, '0, 48'(1) << 37, "R8 masked-off flag");
        ev('0, '0, '0, 48'(1) << 36, "R8 enabled flag");
        rd(8'h52, "R8 flags lo");
        ev('0, '0, '0, 48'(1) << 47, "R8 hi enabled flag");
        rd(8'h51, "R8 flags hi");

        // R9: injection edge behaviour
        wr(8'h40, 8'h01, "R9 first framing request");
        ev('0, '0, '0, '0, "R9 no second pulse");
        wr(8'h40, 8'h01, "R9 repeat 1 while held");
        rd(8'h40, "R9 ctrl readback held");
        wr(8'h40, 8'h00, "R9 rearm");
        wr(8'h40, 8'h03, "R9 both requests");
        wr(8'h40, 8'h00, "R9 rearm");
        wr(8'h20, 8'h02, "R9 ch0 parity");
        wr(8'h20, 8'h00, "R9 fire then zero next");
        rd(8'h20, "R9 ctrl readback idle");

        // R10: unmapped reads, ignored writes
        rd(8'h28, "R10 offset 8");
        rd(8'h05, "R10 below window");
        rd(8'h70, "R10 above window");
        repeat (4) ev(4'b0001, '0, '0, '0, "R10");
        wr(8'h25, 8'h55, "R10 write to counter");
        rd(8'h25, "R10 counter unchanged by write");
        wr(8'h22, 8'hFF, "R10 write to flags");
        rd(8'h22, "R10 flags unchanged by write");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 10);
            logic [7:0] a = 8'(24 + $urandom % 80);
            logic [3:0] pe = 4'($urandom & $urandom & $urandom);
            logic [3:0] le = 4'($urandom & $urandom & $urandom);
            logic [3:0] fe = 4'($urandom & $urandom & $urandom);
            logic [47:0] es = {16'($urandom & $urandom & $urandom & $urandom),
                               32'($urandom & $urandom & $urandom & $urandom)};
            if (r < 4)      step(a, 1'b1, 1'b0, 8'h00, pe, le, fe, es, "R3 random read");
            else if (r < 6) step(a, 1'b0, 1'b1, 8'($urandom), pe, le, fe, es, "R9 random write");
            else            step(a, 1'b0, 1'b0, 8'h00, pe, le, fe, es, "R7 random idle");
        end

        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 8; o++)
                rd(8'(32 + 16*c + o), "R4 final drain");

        finish_run();
    end

endmodule